// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation cache after a lookup misses. It takes the missing virtual address and walks a two-level page table held in memory. It splits the 20-bit virtual page number into two 10-bit indices. The upper index selects an entry in the root table, and the lower index selects an entry in the second-level table that the root entry points to. It makes exactly one memory read per level, and the second read depends on the first. When the walk ends it returns either the leaf entry, ready to be inserted into the cache, or a fault report that names the level where an invalid entry was found.

The miss side and the response side are valid/ready streams. The walker handles one miss at a time, and `miss_ready_o` is high only while the walker is idle. A response stays on the outputs, unchanged, until the consumer raises `rsp_ready_i`. The memory side issues a valid/ready read request. The request address and valid stay stable until the memory raises ready. The memory then returns one word, flagged by `mem_rsp_valid_i`, after any number of cycles. The memory has no ready on its response path, so the walker always accepts the word. The root table sits at the page whose frame number is on `root_frame_i`, and that input is sampled when a miss is accepted.

Entry format: bit 0 marks the entry valid, bit 1 marks the page writable, and bits 31:12 hold the frame number of the next table or of the final page.

Top module: `pt_walker`

## Requirements
- R1: After reset, `miss_ready_o` is 1 and `rsp_valid_o` and `mem_req_valid_o` are 0.
- R2: The first memory read of a walk goes to address {root frame, 12'h000} + vaddr[31:22]*4. The root frame is the value of `root_frame_i` in the cycle the miss is accepted. Later changes to that input have no effect on the walk in progress.
- R3: The second read is issued only after the root entry has returned with bit 0 set. It goes to {root entry[31:12], 12'h000} + vaddr[21:12]*4.
- R4: If the root entry has bit 0 clear, the walk ends after exactly one read. The response has `rsp_fault_o`=1 and `rsp_leaf_o`=0, and `rsp_pte_o` carries the root entry.
- R5: If the leaf entry has bit 0 clear, the walk ends after two reads. The response has `rsp_fault_o`=1 and `rsp_leaf_o`=1, and `rsp_pte_o` carries the leaf entry.
- R6: A successful walk responds with `rsp_fault_o`=0, `rsp_leaf_o`=1, `rsp_pte_o` equal to the leaf entry (bit 1 included), and `rsp_vaddr_o` equal to the missing address.
- R7: While `mem_req_valid_o` is 1 and `mem_req_ready_i` is 0, the request and its address stay unchanged into the next cycle.
- R8: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, the response and all of its fields stay unchanged. The walker returns to idle in the cycle after the response is taken.
- R9: `miss_ready_o` is 0 from the cycle after a miss is accepted until the response is taken. A miss presented during that time is not accepted.
- R10: A `mem_rsp_valid_i` pulse that arrives while no read is outstanding is ignored. The walker stays idle and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_frame_i | input | 20 | Frame number of the root table |
| miss_valid_i | input | 1 | Miss request valid |
| miss_ready_o | output | 1 | Walker idle, accepts a miss |
| miss_vaddr_i | input | 32 | Virtual address that missed |
| rsp_valid_o | output | 1 | Walk result valid |
| rsp_ready_i | input | 1 | Consumer takes the result |
| rsp_vaddr_o | output | 32 | Address that was walked |
| rsp_pte_o | output | 32 | Leaf entry, or the invalid entry on a fault |
| rsp_fault_o | output | 1 | Walk hit an invalid entry |
| rsp_leaf_o | output | 1 | Level of `rsp_pte_o`: 0 root, 1 leaf |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 32 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |

## Verification
The assertions are evaluated on every cycle. They cover the handshake rules: requests and responses are held under back-pressure, an accepted miss always starts a root read, at most one of idle, requesting and responding is true at a time, and a non-faulting result is always a valid leaf entry. Some properties can be shown only by the directed scenarios, which compare against an independent memory model. These are the exact entry addresses at both levels, including the all-ones indices, and the number of reads for each outcome. The scenarios also show that the root frame is latched at acceptance, that misses offered during a walk are refused, and that stray memory responses while idle are ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROOT_REQ,
    ST_ROOT_WAIT,
    ST_LEAF_REQ,
    ST_LEAF_WAIT,
    ST_DONE
  } walk_state_e;

  localparam int unsigned PTE_VALID_BIT = 0;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned PTE_BYTES = 4
) (
  input  logic                      leaf_i,
  input  logic [PA_W-PAGE_BITS-1:0] root_frame_i,
  input  logic [PA_W-PAGE_BITS-1:0] next_frame_i,
  input  logic [VA_W-PAGE_BITS-1:0] vpn_i,
  output logic [PA_W-1:0]           addr_o
);
  localparam int unsigned VPN_W     = VA_W - PAGE_BITS;
  localparam int unsigned LO_W      = VPN_W / 2;
  localparam int unsigned HI_W      = VPN_W - LO_W;
  localparam int unsigned FRAME_W   = PA_W - PAGE_BITS;
  localparam int unsigned PTE_SHIFT = $clog2(PTE_BYTES);

  logic [HI_W-1:0]    idx;
  logic [FRAME_W-1:0] frame;
  logic [PA_W-1:0]    offset;

  // Level select picks both the table base and the index slice.
  always_comb begin
    if (leaf_i) begin
      idx   = HI_W'(vpn_i[LO_W-1:0]);
      frame = next_frame_i;
    end else begin
      idx   = vpn_i[VPN_W-1:LO_W];
      frame = root_frame_i;
    end
    offset = PA_W'(idx) << PTE_SHIFT;
    addr_o = {frame, {PAGE_BITS{1'b0}}} + offset;
  end
endmodule

// File: rtl/ptw_seq.sv
module ptw_seq
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned PTE_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PA_W-PAGE_BITS-1:0] root_frame_i,
  input  logic                      miss_valid_i,
  output logic                      miss_ready_o,
  input  logic [VA_W-1:0]           miss_vaddr_i,
  output logic                      rsp_valid_o,
  input  logic                      rsp_ready_i,
  output logic [VA_W-1:0]           rsp_vaddr_o,
  output logic [PTE_BYTES*8-1:0]    rsp_pte_o,
  output logic                      rsp_fault_o,
  output logic                      rsp_leaf_o,
  output logic                      mem_req_valid_o,
  input  logic                      mem_req_ready_i,
  input  logic                      mem_rsp_valid_i,
  input  logic [PTE_BYTES*8-1:0]    mem_rsp_data_i,
  output logic                      leaf_sel_o,
  output logic [PA_W-PAGE_BITS-1:0] root_frame_o,
  output logic [PA_W-PAGE_BITS-1:0] next_frame_o,
  output logic [VA_W-PAGE_BITS-1:0] vpn_o
);
  localparam int unsigned FRAME_W = PA_W - PAGE_BITS;
  localparam int unsigned PTE_W   = PTE_BYTES * 8;

  walk_state_e        state_q;
  logic [VA_W-1:0]    vaddr_q;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] next_q;
  logic [PTE_W-1:0]   pte_q;
  logic               fault_q;
  logic               leaf_q;
  logic               entry_ok;

  assign entry_ok = mem_rsp_data_i[PTE_VALID_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vaddr_q <= '0;
      root_q  <= '0;
      next_q  <= '0;
      pte_q   <= '0;
      fault_q <= 1'b0;
      leaf_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (miss_valid_i) begin
          vaddr_q <= miss_vaddr_i;
          root_q  <= root_frame_i;
          state_q <= ST_ROOT_REQ;
        end
        ST_ROOT_REQ: if (mem_req_ready_i) state_q <= ST_ROOT_WAIT;
        ST_ROOT_WAIT: if (mem_rsp_valid_i) begin
          pte_q <= mem_rsp_data_i;
          if (!entry_ok) begin
            fault_q <= 1'b1;
            leaf_q  <= 1'b0;
            state_q <= ST_DONE;
          end else begin
            next_q  <= mem_rsp_data_i[PAGE_BITS +: FRAME_W];
            state_q <= ST_LEAF_REQ;
          end
        end
        ST_LEAF_REQ: if (mem_req_ready_i) state_q <= ST_LEAF_WAIT;
        ST_LEAF_WAIT: if (mem_rsp_valid_i) begin
          pte_q   <= mem_rsp_data_i;
          fault_q <= !entry_ok;
          leaf_q  <= 1'b1;
          state_q <= ST_DONE;
        end
        ST_DONE: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign miss_ready_o    = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_ROOT_REQ) || (state_q == ST_LEAF_REQ);
  assign rsp_valid_o     = (state_q == ST_DONE);
  assign leaf_sel_o      = (state_q == ST_LEAF_REQ);
  assign rsp_vaddr_o     = vaddr_q;
  assign rsp_pte_o       = pte_q;
  assign rsp_fault_o     = fault_q;
  assign rsp_leaf_o      = leaf_q;
  assign root_frame_o    = root_q;
  assign next_frame_o    = next_q;
  assign vpn_o           = vaddr_q[VA_W-1:PAGE_BITS];

  // R2
  miss_starts_root_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid_i && miss_ready_o |=> mem_req_valid_o && !leaf_sel_o);

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_pte_o) &&
      $stable(rsp_fault_o) && $stable(rsp_leaf_o) && $stable(rsp_vaddr_o));

  // R9
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({miss_ready_o, mem_req_valid_o, rsp_valid_o}));

  // R6
  good_result_is_valid_leaf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_fault_o |-> rsp_leaf_o && rsp_pte_o[PTE_VALID_BIT]);

  // R4
  root_result_is_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_leaf_o |-> rsp_fault_o && !rsp_pte_o[PTE_VALID_BIT]);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned PTE_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PA_W-PAGE_BITS-1:0] root_frame_i,
  input  logic                      miss_valid_i,
  output logic                      miss_ready_o,
  input  logic [VA_W-1:0]           miss_vaddr_i,
  output logic                      rsp_valid_o,
  input  logic                      rsp_ready_i,
  output logic [VA_W-1:0]           rsp_vaddr_o,
  output logic [PTE_BYTES*8-1:0]    rsp_pte_o,
  output logic                      rsp_fault_o,
  output logic                      rsp_leaf_o,
  output logic                      mem_req_valid_o,
  input  logic                      mem_req_ready_i,
  output logic [PA_W-1:0]           mem_req_addr_o,
  input  logic                      mem_rsp_valid_i,
  input  logic [PTE_BYTES*8-1:0]    mem_rsp_data_i
);
  localparam int unsigned FRAME_W = PA_W - PAGE_BITS;
  localparam int unsigned VPN_W   = VA_W - PAGE_BITS;

  logic               leaf_sel;
  logic [FRAME_W-1:0] root_frame;
  logic [FRAME_W-1:0] next_frame;
  logic [VPN_W-1:0]   vpn;

  ptw_seq #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .PTE_BYTES(PTE_BYTES)
  ) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .root_frame_i    (root_frame_i),
    .miss_valid_i    (miss_valid_i),
    .miss_ready_o    (miss_ready_o),
    .miss_vaddr_i    (miss_vaddr_i),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_ready_i     (rsp_ready_i),
    .rsp_vaddr_o     (rsp_vaddr_o),
    .rsp_pte_o       (rsp_pte_o),
    .rsp_fault_o     (rsp_fault_o),
    .rsp_leaf_o      (rsp_leaf_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .leaf_sel_o      (leaf_sel),
    .root_frame_o    (root_frame),
    .next_frame_o    (next_frame),
    .vpn_o           (vpn)
  );

  ptw_addr_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .PTE_BYTES(PTE_BYTES)
  ) u_addr (
    .leaf_i       (leaf_sel),
    .root_frame_i (root_frame),
    .next_frame_i (next_frame),
    .vpn_i        (vpn),
    .addr_o       (mem_req_addr_o)
  );

  // R7
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  // R10
  idle_ignores_mem_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready_o && !miss_valid_i |=> miss_ready_o && !mem_req_valid_o);
endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] root_frame = '0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_vaddr;
  logic [31:0] rsp_pte;
  logic        rsp_fault;
  logic        rsp_leaf;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  always #2.5 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .root_frame_i(root_frame),
    .miss_valid_i(miss_valid), .miss_ready_o(miss_ready), .miss_vaddr_i(miss_vaddr),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_vaddr_o(rsp_vaddr),
    .rsp_pte_o(rsp_pte), .rsp_fault_o(rsp_fault), .rsp_leaf_o(rsp_leaf),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data)
  );

  logic [31:0] mem [logic [31:0]];
  int          lat = 1;
  int          gap = 0;
  int          gap_cnt = 0;
  int          rsp_cnt = 0;
  logic [31:0] held_addr = '0;
  int          req_n = 0;
  logic [31:0] req_log [4];
  bit          spur = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model: decides ready at each negedge, so the handshake it sees is
  // the one the design samples at the following posedge.
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (spur) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'hFFFF_FFFF;
        spur = 1'b0;
      end
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem.exists(held_addr) ? mem[held_addr] : 32'h0;
        end
      end
      if (mem_req_valid && gap_cnt < gap) begin
        mem_req_ready = 1'b0;
        gap_cnt++;
      end else begin
        mem_req_ready = 1'b1;
      end
      if (mem_req_valid && mem_req_ready) begin
        held_addr = mem_req_addr;
        rsp_cnt   = lat;
        if (req_n < 4) req_log[req_n] = mem_req_addr;
        req_n++;
        gap_cnt = 0;
      end
    end
  end

  // Runs one walk; hold = cycles the response is back-pressured.
  task automatic walk(input logic [31:0] va, input logic [19:0] root, input int hold,
                      input logic [19:0] root_late, input bit poke_busy,
                      output logic [31:0] pte, output logic fault, output logic leaf);
    int t;
    @(negedge clk);
    req_n = 0;
    root_frame = root;
    miss_vaddr = va;
    miss_valid = 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
    root_frame = root_late;
    if (poke_busy) begin
      miss_valid = 1'b1;
      miss_vaddr = 32'h0BAD_0000;
      chk("R9 miss_ready low during walk", {31'b0, miss_ready}, 32'h0);
      @(negedge clk);
      chk("R9 miss_ready still low", {31'b0, miss_ready}, 32'h0);
      miss_valid = 1'b0;
    end
    t = 0;
    while (!rsp_valid && t < 2000) begin
      @(negedge clk);
      t++;
    end
    pte   = rsp_pte;
    fault = rsp_fault;
    leaf  = rsp_leaf;
    chk("R6 rsp_vaddr", rsp_vaddr, va);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R8 rsp held valid", {31'b0, rsp_valid}, 32'h1);
      chk("R8 rsp pte stable", rsp_pte, pte);
      chk("R9 no accept while responding", {31'b0, miss_ready}, 32'h0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R8 idle after take", {31'b0, miss_ready}, 32'h1);
    chk("R8 rsp dropped", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic t_reset();
    chk("R1 miss_ready", {31'b0, miss_ready}, 32'h1);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R1 mem_req_valid", {31'b0, mem_req_valid}, 32'h0);
  endtask

  task automatic t_success();
    logic [31:0] p; logic f; logic l;
    lat = 1; gap = 0;
    walk(32'h0040_3ABC, 20'h00010, 0, 20'h00010, 1'b0, p, f, l);
    chk("R2 root address", req_log[0], 32'h0001_0004);
    chk("R3 leaf address", req_log[1], 32'h0002_000C);
    chk("R6 read count", req_n, 2);
    chk("R6 pte", p, 32'h1234_5003);
    chk("R6 fault", {31'b0, f}, 32'h0);
    chk("R6 leaf level", {31'b0, l}, 32'h1);
  endtask

  task automatic t_root_fault();
    logic [31:0] p; logic f; logic l;
    walk(32'h0140_0000, 20'h00010, 0, 20'h00010, 1'b0, p, f, l);
    chk("R4 root address", req_log[0], 32'h0001_0014);
    chk("R4 one read", req_n, 1);
    chk("R4 fault", {31'b0, f}, 32'h1);
    chk("R4 level root", {31'b0, l}, 32'h0);
    chk("R4 pte", p, 32'h0);
  endtask

  task automatic t_leaf_fault();
    logic [31:0] p; logic f; logic l;
    walk(32'h0040_7000, 20'h00010, 0, 20'h00010, 1'b0, p, f, l);
    chk("R5 leaf address", req_log[1], 32'h0002_001C);
    chk("R5 two reads", req_n, 2);
    chk("R5 fault", {31'b0, f}, 32'h1);
    chk("R5 level leaf", {31'b0, l}, 32'h1);
    chk("R5 pte", p, 32'h5555_5002);
  endtask

  task automatic t_stall_edges();
    logic [31:0] p; logic f; logic l;
    lat = 5; gap = 3;
    walk(32'hFFFF_FFFF, 20'h00030, 4, 20'h00077, 1'b1, p, f, l);
    chk("R2 root address latched at accept", req_log[0], 32'h0003_0FFC);
    chk("R3 leaf address max index", req_log[1], 32'h0004_0FFC);
    chk("R7 one request per level", req_n, 2);
    chk("R6 pte with writable", p, 32'hABCD_E007);
    chk("R6 fault", {31'b0, f}, 32'h0);
    lat = 1; gap = 0;
  endtask

  task automatic t_stray_rsp();
    logic [31:0] p; logic f; logic l;
    @(negedge clk);
    req_n = 0;
    spur = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 still idle", {31'b0, miss_ready}, 32'h1);
    chk("R10 no response", {31'b0, rsp_valid}, 32'h0);
    chk("R10 no request", req_n, 0);
    walk(32'h0040_3ABC, 20'h00010, 0, 20'h00010, 1'b0, p, f, l);
    chk("R10 next walk intact", p, 32'h1234_5003);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    mem[32'h0001_0004] = 32'h0002_0001;
    mem[32'h0002_000C] = 32'h1234_5003;
    mem[32'h0001_0014] = 32'h0000_0000;
    mem[32'h0002_001C] = 32'h5555_5002;
    mem[32'h0003_0FFC] = 32'h0004_0001;
    mem[32'h0004_0FFC] = 32'hABCD_E007;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_success();
    t_root_fault();
    t_leaf_fault();
    t_stall_edges();
    t_stray_rsp();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule